// File: doc/BRIEF.md
# Streaming SPI Shift Core

This core runs a single SPI transfer of one or more words. A start pulse latches the word count and the read and write enables, then the core clocks each word over SCLK, SDO and SDI. Write words are fetched from a ready/valid input stream, and each received word is pushed onto a ready/valid output stream. The SCLK rate comes from a clock divider. The idle level and the sampling edge come from polarity and phase settings. The word length in bits can be set at run time to any value from 1 up to the data width.

The core only moves from one word to the next at a word boundary. If the write stream has no word ready, or the read stream will not take the finished word, SCLK holds at its idle level until the handshake completes. The SDO output-enable (active low) is asserted for the whole of a write transfer. A one-cycle done pulse marks the end of the transfer. Command decoding and chip-select control belong to the surrounding logic.

Top module: `spi_shift_core`

## Requirements
- R1: A start pulse in idle with count n moves exactly n+1 words. busy is high from the cycle after start until done. done is a one-cycle pulse issued once the last word is handed off, with busy low in the following cycle.
- R2: Within a word, consecutive SCLK transitions are exactly cfg_div+1 clock cycles apart.
- R3: SCLK rests at cfg_cpol while idle, and it is back at cfg_cpol after every word.
- R4: SCLK transitions are numbered from 0 within a word, where transition 0 is the leading edge. With cfg_cpha=0, SDO/SDI bits are sampled on the odd (trailing) transitions and change on the even ones. With cfg_cpha=1, sampling is on the even (leading) transitions.
- R5: sdo_t is low from the first word to the last word of a transfer with cmd_wr=1, and high at all other times. SDO is low whenever sdo_t is high.
- R6: With cmd_wr=1, each word takes one tx_valid/tx_ready handshake before its first SCLK transition. The low L bits of that tx_data word are sent most significant bit first.
- R7: While a word waits for tx_valid, or a finished word waits for rx_ready, SCLK does not move and rx_data holds steady.
- R8: With cmd_rd=1, each word raises rx_valid once. The L bits read (first received bit in the most significant place) sit in rx_data[L-1:0] and the upper bits are zero. With cmd_rd=0, rx_valid never rises.
- R9: The word length L is cfg_len when cfg_len is between 1 and DATA_WIDTH. A value of 0 or above DATA_WIDTH gives L = DATA_WIDTH.
- R10: A start pulse while busy is ignored: the running transfer keeps its count, length and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transfer when idle |
| cmd_rd | input | 1 | Read enable, latched at start |
| cmd_wr | input | 1 | Write enable, latched at start |
| cmd_count | input | CNT_W | Word count minus one, latched at start |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_div | input | DIV_W | SCLK half-period minus one, in clocks |
| cfg_len | input | $clog2(DATA_WIDTH+1) | Word length in bits, 0 = DATA_WIDTH |
| tx_data | input | DATA_WIDTH | Write word |
| tx_valid | input | 1 | Write word available |
| tx_ready | output | 1 | Core takes a write word |
| rx_data | output | DATA_WIDTH | Read word, right-aligned |
| rx_valid | output | 1 | Read word available |
| rx_ready | input | 1 | Sink takes the read word |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_t | output | 1 | SDO output disable (low = drive) |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench acts as an SPI peripheral. It samples SDO and updates SDI on the edges that R4 assigns, so a phase or polarity error shows up as corrupted words rather than going unnoticed. The four mode combinations are run with dividers from 0 to 3, word lengths of 1, 0 (full width) and values in between, and the read-only, write-only and neither cases. This separates errors in bit order, masking and output-enable gating. Random idle gaps on both streams catch an SCLK that runs during a stall. A long 256-word run exercises the count boundary. A second start pulse during a transfer must not change the number of SCLK transitions.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_PUSH  = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_t;
endpackage

// File: rtl/spi_prescale.sv
module spi_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tick = run && (cnt_q == div);

  // R2: with a divider above zero, two ticks never land on adjacent cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && run) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW    = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DW-1:0]    load_word,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             sdi,
  input  logic [LEN_W-1:0] len,
  output logic             sdo_bit,
  output logic [DW-1:0]    rx_word
);
  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= {tx_q[DW-2:0], 1'b0};
      if (rx_en) rx_q <= {rx_q[DW-2:0], sdi};
    end
  end

  // the outgoing bit sits at position len-1 of the transmit register
  always_comb begin
    sdo_bit = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i == int'(len) - 1) sdo_bit = tx_q[i];
    end
  end

  assign rx_word = rx_q;

  // R8: a freshly loaded word starts with an empty receive register
  p_rx_clear_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> rx_q == '0);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_core_pkg::*;
#(
  parameter int DATA_WIDTH = 8,
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 8,
  localparam int LEN_W     = $clog2(DATA_WIDTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  cmd_rd,
  input  logic                  cmd_wr,
  input  logic [CNT_W-1:0]      cmd_count,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cpha,
  input  logic [DIV_W-1:0]      cfg_div,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic [DATA_WIDTH-1:0] tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic [DATA_WIDTH-1:0] rx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  sdo_t,
  input  logic                  sdi,
  output logic                  busy,
  output logic                  done
);
  localparam int EDGE_W = LEN_W + 1;

  xfer_state_t      state_q;
  logic             rd_q, wr_q, cpha_q, sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q, len_eff;
  logic [DIV_W-1:0] div_q;
  logic [EDGE_W-1:0] edge_q, edge_last;
  logic             tick, sample_ev, change_ev, load_ev, push_ok, drive_on, sdo_bit;

  assign len_eff   = (cfg_len == '0 || cfg_len > LEN_W'(DATA_WIDTH)) ? LEN_W'(DATA_WIDTH) : cfg_len;
  assign edge_last = {len_q, 1'b0} - EDGE_W'(1);

  spi_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk (clk),
    .rst (rst),
    .run (state_q == ST_SHIFT),
    .div (div_q),
    .tick(tick)
  );

  assign sample_ev = tick && (edge_q[0] != cpha_q);
  assign change_ev = tick && (edge_q[0] == cpha_q) && (edge_q != '0);
  assign load_ev   = (state_q == ST_LOAD) && (!wr_q || tx_valid);
  assign push_ok   = (state_q == ST_PUSH) && (!rd_q || rx_ready);

  spi_shifter #(.DW(DATA_WIDTH), .LEN_W(LEN_W)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .load     (load_ev),
    .load_word(wr_q ? tx_data : '0),
    .tx_en    (change_ev),
    .rx_en    (sample_ev),
    .sdi      (sdi),
    .len      (len_q),
    .sdo_bit  (sdo_bit),
    .rx_word  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(DATA_WIDTH);
      div_q   <= '0;
      edge_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (start) begin
            rd_q    <= cmd_rd;
            wr_q    <= cmd_wr;
            cnt_q   <= cmd_count;
            cpha_q  <= cfg_cpha;
            div_q   <= cfg_div;
            len_q   <= len_eff;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          edge_q <= '0;
          if (load_ev) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (edge_q == edge_last) state_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (push_ok) begin
            if (cnt_q == '0) begin
              state_q <= ST_DONE;
            end else begin
              cnt_q   <= cnt_q - CNT_W'(1);
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_on = wr_q && (state_q == ST_LOAD || state_q == ST_SHIFT || state_q == ST_PUSH);
  assign tx_ready = (state_q == ST_LOAD) && wr_q;
  assign rx_valid = (state_q == ST_PUSH) && rd_q;
  assign sclk     = sclk_q;
  assign sdo_t    = ~drive_on;
  assign sdo      = drive_on & sdo_bit;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);

  // R3: a finished word leaves SCLK at its idle level
  p_word_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PUSH) |-> sclk == cfg_cpol);

  // R7: no SCLK movement while waiting on either stream
  p_stall_sclk_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD || state_q == ST_PUSH) |=> $stable(sclk));

  // R7: an unaccepted read word holds steady
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));

  // R5: output enable released whenever the core is idle
  p_sdo_t_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sdo_t && !sdo);

  // R1: done is a single-cycle pulse followed by idle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  // R10: a start during a word does not disturb the latched command
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (start && state_q == ST_SHIFT) |=> $stable(rd_q) && $stable(wr_q) && $stable(len_q));
endmodule

// File: tb/spi_shift_core_bench.sv
module spi_shift_core_bench;
  localparam int DW    = 8;
  localparam int LEN_W = $clog2(DW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [7:0] cmd_count = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [DW-1:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, sdi = 1'b0;
  logic tx_ready, rx_valid, sclk, sdo, sdo_t, busy, done;
  logic [DW-1:0] rx_data;

  always #5 clk = ~clk;

  spi_shift_core #(.DATA_WIDTH(DW), .CNT_W(8), .DIV_W(8)) u_spi_shift_core (
    .clk(clk), .rst(rst), .start(start), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_count(cmd_count), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .sdo(sdo), .sdo_t(sdo_t), .sdi(sdi), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;

  logic [DW-1:0] tx_mem [256];
  logic [DW-1:0] sl_mem [256];
  int t_rd, t_wr, t_n, t_cpol, t_cpha, t_div, t_len, t_stall;
  int src_cnt, snk_cnt, edge_total, bad_gap, bad_sdo, bad_sdot, bad_idle, bad_rx, bad_stall, bad_side;
  bit done_seen;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l == 0 || l > DW) ? DW : l;
  endfunction

  function automatic logic [DW-1:0] rx_expect(input logic [DW-1:0] w, input int l);
    logic [DW-1:0] m;
    m = (l >= DW) ? '1 : DW'((1 << l) - 1);
    return w & m;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  task automatic source();
    for (int i = 0; i <= t_n; i++) begin
      repeat ($urandom_range(0, t_stall)) @(negedge clk);
      tx_data  = tx_mem[i];
      tx_valid = 1'b1;
      while (1) begin
        if (tx_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
      tx_valid = 1'b0;
      tx_data  = DW'($urandom);
      src_cnt++;
    end
  endtask

  task automatic sink();
    logic [DW-1:0] got;
    for (int i = 0; i <= t_n; i++) begin
      rx_ready = 1'b0;
      repeat ($urandom_range(0, t_stall)) @(negedge clk);
      rx_ready = 1'b1;
      while (1) begin
        if (rx_valid) begin got = rx_data; @(negedge clk); break; end
        @(negedge clk);
      end
      rx_ready = 1'b0;
      if (got !== rx_expect(sl_mem[i], t_len)) bad_rx++;
      snk_cnt++;
    end
  endtask

  task automatic monitor();
    logic prev;
    int k = 0, w = 0, gap = 0, b;
    bit stall_prev = 1'b0;
    logic exp_bit;
    prev = sclk;
    sdi  = sl_mem[0][t_len-1];
    while (1) begin
      @(negedge clk);
      gap++;
      if (done) begin
        done_seen = 1'b1;
        if (sclk !== 1'(t_cpol)) bad_idle++;
        break;
      end
      if (!t_rd && rx_valid) bad_side++;
      if (!t_wr && tx_ready) bad_side++;
      if (sclk !== prev) begin
        prev = sclk;
        edge_total++;
        if (stall_prev) bad_stall++;
        if (k != 0 && gap != t_div + 1) bad_gap++;
        gap = 0;
        if ((k % 2) != t_cpha) begin
          b = k / 2;
          exp_bit = t_wr ? tx_mem[w][t_len-1-b] : 1'b0;
          if (sdo !== exp_bit) bad_sdo++;
          if (sdo_t !== 1'(!t_wr)) bad_sdot++;
          if (b + 1 < t_len) sdi = sl_mem[w][t_len-2-b];
          else if (w + 1 <= t_n) sdi = sl_mem[w+1][t_len-1];
        end
        k++;
        if (k == 2 * t_len) begin
          k = 0;
          w++;
          if (sclk !== 1'(t_cpol)) bad_idle++;
        end
      end
      stall_prev = (tx_ready && !tx_valid) || (rx_valid && !rx_ready);
    end
  endtask

  task automatic injector();
    repeat (3) @(negedge clk);
    start     = 1'b1;
    cmd_count = 8'(t_n + 5);
    cmd_rd    = 1'b0;
    cmd_wr    = 1'b0;
    cfg_len   = LEN_W'(1);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input int rd, input int wr, input int n, input int cpol, input int cpha,
                          input int div, input int len, input int stall, input int inject);
    t_rd = rd; t_wr = wr; t_n = n; t_cpol = cpol; t_cpha = cpha; t_div = div;
    t_len = eff_len(len); t_stall = stall;
    src_cnt = 0; snk_cnt = 0; edge_total = 0; bad_gap = 0; bad_sdo = 0; bad_sdot = 0;
    bad_idle = 0; bad_rx = 0; bad_stall = 0; bad_side = 0; done_seen = 1'b0;
    for (int i = 0; i <= n; i++) begin
      tx_mem[i] = DW'($urandom);
      sl_mem[i] = DW'($urandom);
    end
    cfg_cpol = 1'(cpol); cfg_cpha = 1'(cpha); cfg_div = 8'(div); cfg_len = LEN_W'(len);
    repeat (2) @(negedge clk);
    check(sclk === 1'(cpol), "R3", "idle sclk level", int'(sclk), cpol);
    cmd_rd = 1'(rd); cmd_wr = 1'(wr); cmd_count = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1", "busy after start", int'(busy), 1);
    fork
      monitor();
      if (wr != 0) source();
      if (rd != 0) sink();
      if (inject != 0) injector();
    join
    cfg_len = LEN_W'(len);
    check(done_seen, "R1", "done seen", int'(done_seen), 1);
    check(edge_total == 2 * t_len * (n + 1), inject ? "R10" : "R1", "sclk transitions",
          edge_total, 2 * t_len * (n + 1));
    check(bad_gap == 0, "R2", "half-period mismatches", bad_gap, 0);
    check(bad_idle == 0, "R3", "word-end sclk level", bad_idle, 0);
    check(bad_sdo == 0, "R4 R6 R9", "sdo bit mismatches", bad_sdo, 0);
    check(bad_sdot == 0, "R5", "sdo_t during transfer", bad_sdot, 0);
    check(bad_stall == 0, "R7", "sclk moved during stall", bad_stall, 0);
    check(bad_side == 0, "R8", "handshake on disabled stream", bad_side, 0);
    if (wr != 0) check(src_cnt == n + 1, "R6", "write handshakes", src_cnt, n + 1);
    if (rd != 0) begin
      check(snk_cnt == n + 1, "R8", "read handshakes", snk_cnt, n + 1);
      check(bad_rx == 0, "R4 R8 R9", "read word mismatches", bad_rx, 0);
    end
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "idle after done", int'(busy), 0);
    check(sdo_t === 1'b1 && sdo === 1'b0, "R5", "sdo_t released", int'(sdo_t), 1);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, inject ? "R10" : "R1", "no restart", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", int'(busy), 0);
    check(sdo_t === 1'b1 && tx_ready === 1'b0 && rx_valid === 1'b0, "R5", "reset sdo_t", int'(sdo_t), 1);
    rst = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0, "R3", "sclk after reset cpol=0", int'(sclk), 0);
    // directed corners
    run_xfer(1, 1, 3,   0, 0, 1, 0, 2, 0); // R9 length 0 means full width
    run_xfer(1, 1, 2,   0, 1, 0, 8, 0, 0);
    run_xfer(1, 1, 2,   1, 0, 2, 5, 3, 0);
    run_xfer(1, 1, 2,   1, 1, 3, 3, 1, 0);
    run_xfer(1, 0, 1,   0, 0, 0, 1, 2, 0); // R9 single-bit words, read only
    run_xfer(0, 1, 4,   1, 0, 0, 7, 4, 0); // write only
    run_xfer(0, 0, 0,   0, 1, 1, 4, 0, 0); // neither stream
    run_xfer(1, 1, 2,   0, 0, 1, 6, 0, 1); // R10 start while busy
    run_xfer(1, 1, 255, 0, 1, 0, 2, 0, 0); // full count range
    // constrained random
    for (int r = 0; r < 24; r++) begin
      run_xfer($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 6),
               $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
               $urandom_range(0, DW), $urandom_range(0, 4), ($urandom_range(0, 3) == 0) ? 1 : 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule